// File: doc/BRIEF.md
# Reset Source Arbiter with Programming-Entry Detect

This block collects every reset request on the chip and turns them into one internal reset. The requests are power-on, supply brown-out, the external active-low reset pin, wake-up-timer expiry, watchdog expiry and a software request. The internal reset is released synchronously. The cause of the most recent reset is held in a register so that firmware can read it after the restart. The block also says whether the I/O pins must go back to input with pull-up or keep their state.

The block measures how long the external pin stays low. A short low pulse gives an ordinary restart. A low phase of at least `HOLD_CYC` clock cycles (166400 at 32 MHz, about 5.2 ms) makes the block enter the programming state when the reset is released. In that state the core stays in reset and a loader listens on the serial port. Firmware can also arm a flag that survives every reset except power-on. When that flag is set, the next reset ends in the programming state with the USB port listening as well, and the flag clears itself on entry.

The block has no data stream. All pins are plain levels, so there is no back-pressure to handle. Power-on, brown-out and the pin are asynchronous and pass through synchronisers. Watchdog, wake-up, software and arm inputs are already in the clock domain.

Top module: `rstmode_ctrl`

## Requirements
- R1: `rst_n_o` is low while any request is active. It rises on the 16th rising edge at which no request is seen. For the synchronised sources (power-on, brown-out, pin) this is the 18th edge after the input goes inactive. For watchdog, wake-up and software it is the 16th edge after the input goes inactive.
- R2: `cause_o` gives the cause code: 1 power-on, 2 brown-out, 3 pin, 4 watchdog, 5 wake-up timer, 6 software. It does not change while the core runs.
- R3: When several causes fall in one reset episode, `cause_o` keeps the highest-priority one (lowest code). A later, higher-priority request in the same episode replaces a lower one. A lower-priority request never replaces a higher one.
- R4: During a reset caused by power-on, brown-out, pin or watchdog, `io_default_o` is high.
- R5: During a reset caused only by the wake-up timer or software, `io_default_o` stays low.
- R6: A pin low phase shorter than `HOLD_CYC` cycles ends in the running state (`rst_n_o` high, `prog_mode_o` low).
- R7: A pin low phase of `HOLD_CYC` cycles or more ends in the programming state with `prog_usb_o` low, i.e. serial port only.
- R8: `arm_set_i` sets the programming-entry flag, visible on `prog_arm_o`. The flag survives non-power-on resets. The next release enters the programming state with `prog_usb_o` high, and the flag is cleared on entry.
- R9: In the programming state `rst_n_o` stays low and `io_default_o` is high. Any new request leaves the state and starts a normal reset episode.
- R10: A pin low phase covering a single rising edge still produces a full reset episode with cause 3.
- R11: `por_req_i` acts at once and asynchronously. It clears the programming-entry flag, sets the cause to 1 and drives `io_default_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req_i | input | 1 | Power-on request, async, active high |
| bor_req_i | input | 1 | Brown-out request, async, active high |
| pin_rst_n_i | input | 1 | External reset pin, async, active low |
| wdt_req_i | input | 1 | Watchdog expiry request |
| wut_req_i | input | 1 | Wake-up timer expiry request |
| sw_req_i | input | 1 | Software reset request |
| arm_set_i | input | 1 | Arms programming entry on the next reset |
| rst_n_o | output | 1 | Internal core reset, active low |
| io_default_o | output | 1 | Force I/O pins to input with pull-up |
| prog_mode_o | output | 1 | Programming state active |
| prog_usb_o | output | 1 | Loader listens on USB as well as serial |
| cause_o | output | 3 | Latched cause of the last reset |
| prog_arm_o | output | 1 | Programming-entry flag |

## Verification
Each reset source is fired alone, with several hold lengths. This separates the cause code and the I/O handling of each source. Pin low phases of one cycle, one cycle below the hold threshold and exactly at it tell the ordinary restart apart from programming entry. Overlapping requests arrive in the same cycle, in rising and in falling priority order, and with one source delayed by the synchroniser; this checks that the cause is replaced only by a higher-priority source. The arm flag is carried across a watchdog reset and then cleared by power-on, which separates the two entry routes and the flag's retention.

// File: rtl/rstm_pkg.sv
package rstm_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_POR  = 3'd1,
    CAUSE_BOR  = 3'd2,
    CAUSE_PIN  = 3'd3,
    CAUSE_WDT  = 3'd4,
    CAUSE_WUT  = 3'd5,
    CAUSE_SW   = 3'd6
  } cause_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_PROG = 2'd2
  } mode_e;

  typedef struct packed {
    logic por;
    logic bor;
    logic pin;
    logic wdt;
    logic wut;
    logic sw;
  } req_t;

  // Highest priority first; a lower code means higher priority.
  function automatic cause_e pick_cause(input req_t r);
    cause_e c;
    if (r.por)      c = CAUSE_POR;
    else if (r.bor) c = CAUSE_BOR;
    else if (r.pin) c = CAUSE_PIN;
    else if (r.wdt) c = CAUSE_WDT;
    else if (r.wut) c = CAUSE_WUT;
    else if (r.sw)  c = CAUSE_SW;
    else            c = CAUSE_NONE;
    return c;
  endfunction

  // Sources that put the pads back to input with pull-up.
  function automatic logic pads_default(input req_t r);
    return r.por | r.bor | r.pin | r.wdt;
  endfunction

endpackage

// File: rtl/rstm_sync.sv
module rstm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_first
      assign nxt = d_i;
    end else begin : g_next
      assign nxt = stage_q[i-1];
    end
    always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) stage_q[i] <= RST_VAL;
      else        stage_q[i] <= nxt;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rstm_pin_meter.sv
module rstm_pin_meter #(
  parameter int HOLD_CYC = 166400
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic low_i,
  output logic long_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] lo_cnt_q;

  // Saturating count of consecutive cycles the synchronised pin is low.
  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i)                  lo_cnt_q <= '0;
    else if (!low_i)             lo_cnt_q <= '0;
    else if (lo_cnt_q != LIMIT)  lo_cnt_q <= lo_cnt_q + CW'(1);
  end

  assign long_o = (lo_cnt_q == LIMIT);
endmodule

// File: rtl/rstm_seq.sv
module rstm_seq
  import rstm_pkg::*;
#(
  parameter int RELEASE_CYC = 16
) (
  input  logic   clk_i,
  input  logic   arst_i,
  input  req_t   req_i,
  input  logic   long_i,
  input  logic   arm_set_i,
  output logic   rst_n_o,
  output logic   io_default_o,
  output logic   prog_mode_o,
  output logic   prog_usb_o,
  output cause_e cause_o,
  output logic   prog_arm_o
);
  localparam int RW = $clog2(RELEASE_CYC + 1);
  localparam logic [RW-1:0] RELOAD = RW'(RELEASE_CYC);

  mode_e         state_q;
  logic [RW-1:0] rel_q;
  cause_e        cause_q;
  logic          io_q, arm_q, long_q, usb_q;

  logic   req_any, starting, io_hit;
  cause_e new_code;

  assign req_any  = |req_i;
  assign starting = (state_q != ST_HOLD);
  assign io_hit   = pads_default(req_i);
  assign new_code = pick_cause(req_i);

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      state_q <= ST_HOLD;
      rel_q   <= RELOAD;
      cause_q <= CAUSE_POR;
      io_q    <= 1'b1;
      arm_q   <= 1'b0;
      long_q  <= 1'b0;
      usb_q   <= 1'b0;
    end else begin
      if (arm_set_i) arm_q <= 1'b1;
      if (req_any) begin
        state_q <= ST_HOLD;
        rel_q   <= RELOAD;
        if (starting || (new_code < cause_q)) cause_q <= new_code;
        io_q    <= (starting ? 1'b0 : io_q) | io_hit;
        long_q  <= (starting ? 1'b0 : long_q) | long_i;
        if (starting) usb_q <= 1'b0;
      end else if (state_q == ST_HOLD) begin
        long_q <= long_q | long_i;
        if (rel_q > RW'(1)) begin
          rel_q <= rel_q - RW'(1);
        end else begin
          rel_q <= '0;
          if (long_q || long_i || arm_q) begin
            state_q <= ST_PROG;
            usb_q   <= arm_q;
            arm_q   <= 1'b0;
          end else begin
            state_q <= ST_RUN;
          end
        end
      end
    end
  end

  assign rst_n_o      = (state_q == ST_RUN);
  assign prog_mode_o  = (state_q == ST_PROG);
  assign prog_usb_o   = (state_q == ST_PROG) & usb_q;
  assign io_default_o = (state_q == ST_PROG) | ((state_q == ST_HOLD) & io_q);
  assign cause_o      = cause_q;
  assign prog_arm_o   = arm_q;
endmodule

// File: rtl/rstmode_ctrl.sv
module rstmode_ctrl
  import rstm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 166400,
  parameter int RELEASE_CYC = 16
) (
  input  logic       clk,
  input  logic       por_req_i,
  input  logic       bor_req_i,
  input  logic       pin_rst_n_i,
  input  logic       wdt_req_i,
  input  logic       wut_req_i,
  input  logic       sw_req_i,
  input  logic       arm_set_i,
  output logic       rst_n_o,
  output logic       io_default_o,
  output logic       prog_mode_o,
  output logic       prog_usb_o,
  output logic [2:0] cause_o,
  output logic       prog_arm_o
);
  logic   por_done, pin_hi, bor_s, long_w;
  req_t   req;
  cause_e cause_w;

  rstm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk_i(clk), .arst_i(por_req_i), .d_i(1'b1), .q_o(por_done));

  rstm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i(clk), .arst_i(por_req_i), .d_i(pin_rst_n_i), .q_o(pin_hi));

  rstm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bor_sync (
    .clk_i(clk), .arst_i(por_req_i), .d_i(bor_req_i), .q_o(bor_s));

  assign req.por = ~por_done;
  assign req.bor = bor_s;
  assign req.pin = ~pin_hi;
  assign req.wdt = wdt_req_i;
  assign req.wut = wut_req_i;
  assign req.sw  = sw_req_i;

  rstm_pin_meter #(.HOLD_CYC(HOLD_CYC)) u_meter (
    .clk_i(clk), .arst_i(por_req_i), .low_i(req.pin), .long_o(long_w));

  rstm_seq #(.RELEASE_CYC(RELEASE_CYC)) u_seq (
    .clk_i        (clk),
    .arst_i       (por_req_i),
    .req_i        (req),
    .long_i       (long_w),
    .arm_set_i    (arm_set_i),
    .rst_n_o      (rst_n_o),
    .io_default_o (io_default_o),
    .prog_mode_o  (prog_mode_o),
    .prog_usb_o   (prog_usb_o),
    .cause_o      (cause_w),
    .prog_arm_o   (prog_arm_o)
  );

  assign cause_o = cause_w;
endmodule

// File: rtl/rstmode_ctrl_chk.sv
module rstmode_ctrl_chk (
  input logic       clk,
  input logic       por_req_i,
  input logic       wdt_req_i,
  input logic       wut_req_i,
  input logic       sw_req_i,
  input logic       rst_n_o,
  input logic       io_default_o,
  input logic       prog_mode_o,
  input logic [2:0] cause_o,
  input logic       prog_arm_o
);
  // R1: a synchronous request holds the core in reset on the next cycle
  a_r1_req_holds: assert property (@(posedge clk) disable iff (por_req_i)
    (wdt_req_i || wut_req_i || sw_req_i) |=> !rst_n_o);

  // R2: the cause does not move while the core keeps running
  a_r2_cause_stable: assert property (@(posedge clk) disable iff (por_req_i)
    (rst_n_o && $past(rst_n_o)) |-> $stable(cause_o));

  // R4: a watchdog reset forces the pads to their default
  a_r4_wdt_pads: assert property (@(posedge clk) disable iff (por_req_i)
    wdt_req_i |=> io_default_o);

  // R8: the arm flag is gone once the programming state is reached
  a_r8_arm_cleared: assert property (@(posedge clk) disable iff (por_req_i)
    $rose(prog_mode_o) |-> !prog_arm_o);

  // R9: a new request leaves the programming state into reset
  a_r9_prog_exit: assert property (@(posedge clk) disable iff (por_req_i)
    (prog_mode_o && (wdt_req_i || wut_req_i || sw_req_i)) |=> (!prog_mode_o && !rst_n_o));

  // R9: the core never runs in the programming state
  a_r9_prog_holds: assert property (@(posedge clk) disable iff (por_req_i)
    prog_mode_o |-> (!rst_n_o && io_default_o));
endmodule

bind rstmode_ctrl rstmode_ctrl_chk i_chk (
  .clk          (clk),
  .por_req_i    (por_req_i),
  .wdt_req_i    (wdt_req_i),
  .wut_req_i    (wut_req_i),
  .sw_req_i     (sw_req_i),
  .rst_n_o      (rst_n_o),
  .io_default_o (io_default_o),
  .prog_mode_o  (prog_mode_o),
  .cause_o      (cause_o),
  .prog_arm_o   (prog_arm_o)
);

// File: tb/test_rstmode_ctrl.sv
module test_rstmode_ctrl;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_req_i = 1'b1, bor_req_i = 1'b0, pin_rst_n_i = 1'b1;
  logic wdt_req_i = 1'b0, wut_req_i = 1'b0, sw_req_i = 1'b0, arm_set_i = 1'b0;
  logic rst_n_o, io_default_o, prog_mode_o, prog_usb_o, prog_arm_o;
  logic [2:0] cause_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  rstmode_ctrl #(.SYNC_STAGES(2), .HOLD_CYC(HOLD), .RELEASE_CYC(16)) i_rstmode_ctrl (
    .clk(clk), .por_req_i(por_req_i), .bor_req_i(bor_req_i), .pin_rst_n_i(pin_rst_n_i),
    .wdt_req_i(wdt_req_i), .wut_req_i(wut_req_i), .sw_req_i(sw_req_i), .arm_set_i(arm_set_i),
    .rst_n_o(rst_n_o), .io_default_o(io_default_o), .prog_mode_o(prog_mode_o),
    .prog_usb_o(prog_usb_o), .cause_o(cause_o), .prog_arm_o(prog_arm_o));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // kind: 0 brown-out, 1 pin, 2 watchdog, 3 wake-up, 4 software
  task automatic drive(input int kind, input logic v);
    case (kind)
      0: bor_req_i = v;
      1: pin_rst_n_i = ~v;
      2: wdt_req_i = v;
      3: wut_req_i = v;
      default: sw_req_i = v;
    endcase
  endtask

  // Called at a negative edge; request is seen on len rising edges.
  task automatic pulse(input int kind, input int len);
    drive(kind, 1'b1);
    repeat (len) @(negedge clk);
    drive(kind, 1'b0);
  endtask

  typedef struct packed {
    logic [2:0] kind;
    logic [7:0] len;
    logic [2:0] cause;
    logic       io;
    logic       prog;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'd2, 8'd1,  3'd4, 1'b1, 1'b0},  // R4 watchdog
    '{3'd3, 8'd1,  3'd5, 1'b0, 1'b0},  // R5 wake-up
    '{3'd4, 8'd3,  3'd6, 1'b0, 1'b0},  // R5 software
    '{3'd1, 8'd1,  3'd3, 1'b1, 1'b0},  // R10 one-edge pin pulse
    '{3'd1, 8'd39, 3'd3, 1'b1, 1'b0},  // R6 just below hold
    '{3'd0, 8'd2,  3'd2, 1'b1, 1'b0},  // R4 brown-out
    '{3'd1, 8'd40, 3'd3, 1'b1, 1'b1},  // R7 hold reached
    '{3'd4, 8'd1,  3'd6, 1'b0, 1'b0},  // R9 leave programming
    '{3'd3, 8'd4,  3'd5, 1'b0, 1'b0}   // R5 wake-up again
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R11 reset state during power-on
    chk("R11 rst_n in por", int'(rst_n_o), 0);
    chk("R11 pads in por", int'(io_default_o), 1);
    chk("R11 cause in por", int'(cause_o), 1);
    chk("R11 arm in por", int'(prog_arm_o), 0);
    chk("R11 prog in por", int'(prog_mode_o), 0);
    por_req_i = 1'b0;
    repeat (17) @(negedge clk);
    chk("R1 por release early", int'(rst_n_o), 0);
    @(negedge clk);
    chk("R1 por release edge", int'(rst_n_o), 1);
    chk("R2 cause after por", int'(cause_o), 1);

    foreach (VECS[i]) begin
      pulse(int'(VECS[i].kind), int'(VECS[i].len));
      repeat (3) @(negedge clk);
      chk($sformatf("R1 vec%0d held", i), int'(rst_n_o), 0);
      chk($sformatf("R4/R5 vec%0d pads", i), int'(io_default_o), int'(VECS[i].io));
      repeat (20) @(negedge clk);
      chk($sformatf("R6/R7 vec%0d run", i), int'(rst_n_o), int'(!VECS[i].prog));
      chk($sformatf("R7/R9 vec%0d prog", i), int'(prog_mode_o), int'(VECS[i].prog));
      chk($sformatf("R7 vec%0d usb", i), int'(prog_usb_o), 0);
      chk($sformatf("R2 vec%0d cause", i), int'(cause_o), int'(VECS[i].cause));
    end

    // R1 exact release for a synchronous source
    pulse(2, 1);
    repeat (15) @(negedge clk);
    chk("R1 wdt release early", int'(rst_n_o), 0);
    @(negedge clk);
    chk("R1 wdt release edge", int'(rst_n_o), 1);

    // R1 exact release for the pin
    pulse(1, 2);
    repeat (17) @(negedge clk);
    chk("R1 pin release early", int'(rst_n_o), 0);
    @(negedge clk);
    chk("R1 pin release edge", int'(rst_n_o), 1);

    // R3 same-cycle watchdog and software
    wdt_req_i = 1; sw_req_i = 1; @(negedge clk); wdt_req_i = 0; sw_req_i = 0;
    repeat (20) @(negedge clk);
    chk("R3 same cycle", int'(cause_o), 4);
    // R3 software first, watchdog later in the episode
    pulse(4, 1); @(negedge clk); pulse(2, 1);
    repeat (20) @(negedge clk);
    chk("R3 upgrade", int'(cause_o), 4);
    // R3 watchdog first, software later
    pulse(2, 1); @(negedge clk); pulse(4, 1);
    repeat (20) @(negedge clk);
    chk("R3 no downgrade", int'(cause_o), 4);
    // R3 brown-out arrives late through its synchroniser
    bor_req_i = 1; wdt_req_i = 1; @(negedge clk); bor_req_i = 0; wdt_req_i = 0;
    repeat (22) @(negedge clk);
    chk("R3 late brown-out", int'(cause_o), 2);
    chk("R3 late brown-out run", int'(rst_n_o), 1);

    // R8 arm, carry across a watchdog reset
    arm_set_i = 1; @(negedge clk); arm_set_i = 0;
    chk("R8 arm set", int'(prog_arm_o), 1);
    pulse(2, 1);
    repeat (20) @(negedge clk);
    chk("R8 prog entered", int'(prog_mode_o), 1);
    chk("R8 usb on", int'(prog_usb_o), 1);
    chk("R8 arm cleared", int'(prog_arm_o), 0);
    chk("R9 core held", int'(rst_n_o), 0);
    chk("R9 pads default", int'(io_default_o), 1);
    pulse(4, 1);
    repeat (20) @(negedge clk);
    chk("R9 back to run", int'(rst_n_o), 1);
    chk("R8 usb off", int'(prog_usb_o), 0);

    // R11 power-on clears the arm flag
    arm_set_i = 1; @(negedge clk); arm_set_i = 0;
    por_req_i = 1; @(negedge clk);
    chk("R11 arm cleared by por", int'(prog_arm_o), 0);
    chk("R11 cause por", int'(cause_o), 1);
    chk("R11 pads por", int'(io_default_o), 1);
    por_req_i = 0;
    repeat (18) @(negedge clk);
    chk("R11 run after por", int'(rst_n_o), 1);
    chk("R11 no prog after por", int'(prog_mode_o), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule